// File: doc/BRIEF.md
# Byte-Granular Vector Operand Aligner

This block sits between a scratchpad and a lane-parallel vector datapath. The datapath handles `LANES` 32-bit lanes, so each word is `W = 4*LANES` bytes wide. A vector operand may begin at any byte address. Two source paths take the full-width words that the fetcher reads from the scratchpad. Each rotates and merges consecutive words so that the first vector byte always appears in byte 0 of lane 0. A destination path takes the datapath results, which are aligned the same way. It rotates them back to the byte offset of the destination address and marks with byte write enables the bytes that belong to the vector.

An operation begins with a one-cycle `op_start` pulse. The pulse carries the byte count and the low address bits, that is, the byte offset inside a word, of both sources and of the destination. Every stream interface uses valid/ready, and a word moves on a clock edge where both are high. A producer holds valid and data steady until the word is taken. Each path stalls its input while its output is held off, and it never drops an output word. After the first fetch, an unaligned operand moves one word per cycle, the same rate as an aligned one.

Top module: `vec_align_net`

## Requirements
- R1: After reset `op_idle` is 1, every output valid is 0, and `src_in_ready` and `res_ready` are 0.
- R2: Byte j of source output word k equals the scratchpad byte at start address + k*W + j. Input word i carries the bytes of word-address floor(start/W)+i, with byte j at bit 8j.
- R3: With offset o and length L > 0, a source path accepts exactly ceil((o+L)/W) input words and emits ceil(L/W) output words. With o ≠ 0 the first input word yields no output. An operation with L = 0 leaves `op_idle` at 1 and moves no words.
- R4: With input valid and output ready held high, a source path emits one output word on every cycle after its first output word.
- R5: When the last input word has been taken but residual bytes still form an output word, the path emits that word without waiting for more input.
- R6: `src_out_keep` bit j is 1 exactly when k*W + j < L. `src_out_last` is 1 only on the final output word.
- R7: Byte j of write word m equals result-stream byte m*W + j − d, where d is the destination offset and result word k holds stream bytes k*W..k*W+W−1.
- R8: `wr_be` bit j is 1 exactly when 0 ≤ m*W + j − d < L. This makes ceil((d+L)/W) writes, and `wr_last` marks the final write.
- R9: While an output is valid and not ready, it stays valid with unchanged data.
- R10: `op_start` is ignored while `op_idle` is 0, and the running operation continues unchanged.
- R11: The two sources may use different offsets in the same operation, and each is aligned correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_start | input | 1 | Start pulse, taken only while idle |
| op_len | input | LW | Vector length in bytes |
| op_src_off | input | 2 x log2(W) | Byte offset of each source start address |
| op_dst_off | input | log2(W) | Byte offset of the destination start address |
| op_idle | output | 1 | All three paths finished |
| src_in_valid | input | 2 | Fetched word valid, per source |
| src_in_ready | output | 2 | Fetched word accepted, per source |
| src_in_data | input | 2 x 8W | Fetched scratchpad words |
| src_out_valid | output | 2 | Aligned word valid |
| src_out_ready | input | 2 | Datapath takes aligned word |
| src_out_data | output | 2 x 8W | Aligned words, element 0 in byte 0 |
| src_out_keep | output | 2 x W | Bytes inside the vector |
| src_out_last | output | 2 | Final aligned word |
| res_valid | input | 1 | Result word valid |
| res_ready | output | 1 | Result word accepted |
| res_data | input | 8W | Aligned result word |
| wr_valid | output | 1 | Scratchpad write valid |
| wr_ready | input | 1 | Write accepted |
| wr_data | output | 8W | Rotated write data |
| wr_be | output | W | Byte write enables |
| wr_last | output | 1 | Final write |

## Verification
Some properties are checked on every cycle. The keep mask is a contiguous run that starts at byte 0. Every write enables at least one byte, and each write before the last reaches the top byte. A word waiting on back-pressure during a flush does not change. A start is never taken by a busy path, and a path is idle right after its last word. The scoreboard scenarios are needed for the rest: byte-exact contents across all offsets, including lengths of one byte and lengths that end inside a residual word. They also cover two sources with different offsets in one operation, back-pressure and input gaps on all three streams, back-to-back output under full flow, and a start pulse sent during a busy operation.

// File: rtl/valign_pkg.sv
`timescale 1ns/1ps
package valign_pkg;
  // number of W-byte words touched by nbytes starting at byte offset off
  function automatic int span_words(int off, int nbytes, int lg);
    if (nbytes == 0) return 0;
    return (off + nbytes + (1 << lg) - 1) >> lg;
  endfunction
endpackage

// File: rtl/valign_byte_rot.sv
`timescale 1ns/1ps
module valign_byte_rot #(
  parameter int W = 8
) (
  input  logic [2*W*8-1:0]      pair_i,
  input  logic [$clog2(W):0]    sh_i,
  output logic [W*8-1:0]        word_o
);
  // byte j of the result is byte (j + sh) of the two-word window
  for (genvar j = 0; j < W; j++) begin : g_byte
    assign word_o[j*8 +: 8] = pair_i[(j + int'(sh_i))*8 +: 8];
  end
endmodule

// File: rtl/valign_src_path.sv
`timescale 1ns/1ps
module valign_src_path #(
  parameter int W  = 8,
  parameter int LW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [$clog2(W)-1:0] off_i,
  input  logic [LW-1:0]        len_i,
  output logic                 busy,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W*8-1:0]       in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W*8-1:0]       out_data,
  output logic [W-1:0]         out_keep,
  output logic                 out_last
);
  localparam int DW = W * 8;
  localparam int OW = $clog2(W);
  localparam int CW = LW + 1;

  logic          busy_q, have_prev;
  logic [OW-1:0] off_q;
  logic [CW-1:0] in_left, out_left, rem;
  logic [DW-1:0] prev;
  logic          bypass, prime, pass, flush, in_fire, out_fire;
  logic [DW-1:0] hi, lo;
  logic [CW-1:0] nin, nout, nxt_in, nxt_out;

  assign nin  = CW'(valign_pkg::span_words(int'(off_i), int'(len_i), OW));
  assign nout = CW'(valign_pkg::span_words(0, int'(len_i), OW));

  always_comb begin
    bypass    = (off_q == '0);
    prime     = busy_q && !bypass && !have_prev && (in_left != '0);
    pass      = busy_q && (in_left != '0) && (bypass || have_prev);
    flush     = busy_q && (in_left == '0) && (out_left != '0);
    in_ready  = prime || (pass && out_ready);
    out_valid = (pass && in_valid) || flush;
    hi        = flush  ? '0 : in_data;
    lo        = bypass ? in_data : prev;
    out_last  = (out_left == CW'(1));
    for (int j = 0; j < W; j++) out_keep[j] = (rem > CW'(j));
    in_fire   = in_valid && in_ready;
    out_fire  = out_valid && out_ready;
    nxt_in    = in_left - CW'(in_fire);
    nxt_out   = out_left - CW'(out_fire);
  end

  valign_byte_rot #(.W(W)) u_rot (
    .pair_i ({hi, lo}),
    .sh_i   ({1'b0, off_q}),
    .word_o (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      have_prev <= 1'b0;
      off_q     <= '0;
      in_left   <= '0;
      out_left  <= '0;
      rem       <= '0;
      prev      <= '0;
    end else if (go) begin
      busy_q    <= (nout != '0);
      have_prev <= 1'b0;
      off_q     <= off_i;
      in_left   <= nin;
      out_left  <= nout;
      rem       <= CW'(len_i);
    end else begin
      if (in_fire) begin
        prev      <= in_data;
        have_prev <= 1'b1;
      end
      if (out_fire) rem <= (rem > CW'(W)) ? rem - CW'(W) : '0;
      in_left  <= nxt_in;
      out_left <= nxt_out;
      busy_q   <= (nxt_in != '0) || (nxt_out != '0);
    end
  end

  assign busy = busy_q;

  // R10
  go_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);
  // R3
  src_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire |-> busy_q);
  // R6
  keep_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_keep[0] && ((out_keep & (out_keep + W'(1))) == '0)));
  // R6
  last_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> !busy_q);
  // R9
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !out_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/valign_dst_path.sv
`timescale 1ns/1ps
module valign_dst_path #(
  parameter int W  = 8,
  parameter int LW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [$clog2(W)-1:0] off_i,
  input  logic [LW-1:0]        len_i,
  output logic                 busy,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [W*8-1:0]       in_data,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [W*8-1:0]       out_data,
  output logic [W-1:0]         out_be,
  output logic                 out_last
);
  localparam int DW = W * 8;
  localparam int OW = $clog2(W);
  localparam int CW = LW + 1;
  localparam int BW = LW + 2;

  logic          busy_q;
  logic [OW-1:0] off_q;
  logic [LW-1:0] len_q;
  logic [CW-1:0] in_left, out_left, nres, nwr, nxt_in, nxt_out;
  logic [BW-1:0] wb;
  logic [DW-1:0] prev, hi;
  logic [OW:0]   sh;
  logic          pass, flush, in_fire, out_fire;

  assign nres = CW'(valign_pkg::span_words(0, int'(len_i), OW));
  assign nwr  = CW'(valign_pkg::span_words(int'(off_i), int'(len_i), OW));

  always_comb begin
    pass      = busy_q && (in_left != '0);
    flush     = busy_q && (in_left == '0) && (out_left != '0);
    in_ready  = pass && out_ready;
    out_valid = (pass && in_valid) || flush;
    hi        = flush ? '0 : in_data;
    sh        = (OW+1)'(W) - {1'b0, off_q};
    out_last  = (out_left == CW'(1));
    for (int j = 0; j < W; j++)
      out_be[j] = ((wb + BW'(j)) >= BW'(off_q)) &&
                  ((wb + BW'(j)) < (BW'(off_q) + BW'(len_q)));
    in_fire   = in_valid && in_ready;
    out_fire  = out_valid && out_ready;
    nxt_in    = in_left - CW'(in_fire);
    nxt_out   = out_left - CW'(out_fire);
  end

  valign_byte_rot #(.W(W)) u_rot (
    .pair_i ({hi, prev}),
    .sh_i   (sh),
    .word_o (out_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      off_q    <= '0;
      len_q    <= '0;
      in_left  <= '0;
      out_left <= '0;
      wb       <= '0;
      prev     <= '0;
    end else if (go) begin
      busy_q   <= (nres != '0);
      off_q    <= off_i;
      len_q    <= len_i;
      in_left  <= nres;
      out_left <= nwr;
      wb       <= '0;
    end else begin
      if (in_fire)  prev <= in_data;
      if (out_fire) wb   <= wb + BW'(W);
      in_left  <= nxt_in;
      out_left <= nxt_out;
      busy_q   <= (nxt_in != '0) || (nxt_out != '0);
    end
  end

  assign busy = busy_q;

  // R8
  be_some_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_be != '0));
  // R8
  be_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_last) |-> out_be[W-1]);
  // R8
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> !busy_q);
  // R9
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_be)));
  // R10
  dst_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy_q);
endmodule

// File: rtl/vec_align_net.sv
`timescale 1ns/1ps
module vec_align_net #(
  parameter int LANES = 2,
  parameter int LW    = 12,
  localparam int W    = LANES * 4,
  localparam int DW   = W * 8,
  localparam int OW   = $clog2(W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_start,
  input  logic [LW-1:0]       op_len,
  input  logic [1:0][OW-1:0]  op_src_off,
  input  logic [OW-1:0]       op_dst_off,
  output logic                op_idle,
  input  logic [1:0]          src_in_valid,
  output logic [1:0]          src_in_ready,
  input  logic [1:0][DW-1:0]  src_in_data,
  output logic [1:0]          src_out_valid,
  input  logic [1:0]          src_out_ready,
  output logic [1:0][DW-1:0]  src_out_data,
  output logic [1:0][W-1:0]   src_out_keep,
  output logic [1:0]          src_out_last,
  input  logic                res_valid,
  output logic                res_ready,
  input  logic [DW-1:0]       res_data,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [DW-1:0]       wr_data,
  output logic [W-1:0]        wr_be,
  output logic                wr_last
);
  logic [2:0] busy_v;
  logic       go;

  assign op_idle = ~|busy_v;
  assign go      = op_start && op_idle;

  for (genvar s = 0; s < 2; s++) begin : g_src
    valign_src_path #(.W(W), .LW(LW)) u_src (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .off_i     (op_src_off[s]),
      .len_i     (op_len),
      .busy      (busy_v[s]),
      .in_valid  (src_in_valid[s]),
      .in_ready  (src_in_ready[s]),
      .in_data   (src_in_data[s]),
      .out_valid (src_out_valid[s]),
      .out_ready (src_out_ready[s]),
      .out_data  (src_out_data[s]),
      .out_keep  (src_out_keep[s]),
      .out_last  (src_out_last[s])
    );
  end

  valign_dst_path #(.W(W), .LW(LW)) u_dst (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go),
    .off_i     (op_dst_off),
    .len_i     (op_len),
    .busy      (busy_v[2]),
    .in_valid  (res_valid),
    .in_ready  (res_ready),
    .in_data   (res_data),
    .out_valid (wr_valid),
    .out_ready (wr_ready),
    .out_data  (wr_data),
    .out_be    (wr_be),
    .out_last  (wr_last)
  );
endmodule

// File: tb/sim_vec_align_net.sv
`timescale 1ns/1ps
module sim_vec_align_net;
  localparam int LANES = 2;
  localparam int LW    = 12;
  localparam int W     = LANES * 4;
  localparam int DW    = W * 8;
  localparam int OW    = $clog2(W);

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 4 ns period

  logic               rst_n = 1'b0;
  logic               op_start = 1'b0;
  logic [LW-1:0]      op_len = '0;
  logic [1:0][OW-1:0] op_src_off = '0;
  logic [OW-1:0]      op_dst_off = '0;
  logic               op_idle;
  logic [1:0]         src_in_valid = '0;
  logic [1:0]         src_in_ready;
  logic [1:0][DW-1:0] src_in_data = '0;
  logic [1:0]         src_out_valid;
  logic [1:0]         src_out_ready = '0;
  logic [1:0][DW-1:0] src_out_data;
  logic [1:0][W-1:0]  src_out_keep;
  logic [1:0]         src_out_last;
  logic               res_valid = 1'b0;
  logic               res_ready;
  logic [DW-1:0]      res_data = '0;
  logic               wr_valid;
  logic               wr_ready = 1'b0;
  logic [DW-1:0]      wr_data;
  logic [W-1:0]       wr_be;
  logic               wr_last;

  vec_align_net #(.LANES(LANES), .LW(LW)) u0 (.*);

  typedef struct { logic [DW-1:0] d; logic [W-1:0] m; logic last; } exp_t;
  exp_t qa[$];
  exp_t qb[$];
  exp_t qd[$];

  int checks = 0, errors = 0, cyc = 0;
  bit stall_mode = 0, fast_a = 0, first_a = 1, finished = 0;
  int last_a = 0;
  bit ps[3];
  logic [DW-1:0] pd[3];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] mem_b(int a);
    return 8'(a * 37 + 11);
  endfunction
  function automatic logic [7:0] res_b(int op, int p);
    return 8'(p * 7 + op * 29 + 3);
  endfunction
  function automatic logic [DW-1:0] bmask(logic [W-1:0] m);
    logic [DW-1:0] r;
    for (int j = 0; j < W; j++) r[j*8 +: 8] = {8{m[j]}};
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_src(int s, int addr, int len);
    int n = (len + W - 1) / W;
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.d = '0; e.m = '0;
      for (int j = 0; j < W; j++)
        if (k*W + j < len) begin e.m[j] = 1'b1; e.d[j*8 +: 8] = mem_b(addr + k*W + j); end
      e.last = (k == n - 1);
      if (s == 0) qa.push_back(e); else qb.push_back(e);
    end
  endtask

  task automatic expect_dst(int op, int d, int len);
    int n = (len == 0) ? 0 : (d + len + W - 1) / W;
    for (int m = 0; m < n; m++) begin
      exp_t e;
      e.d = '0; e.m = '0;
      for (int j = 0; j < W; j++) begin
        int p = m*W + j - d;
        if (p >= 0 && p < len) begin e.m[j] = 1'b1; e.d[j*8 +: 8] = res_b(op, p); end
      end
      e.last = (m == n - 1);
      qd.push_back(e);
    end
  endtask

  task automatic feed_src(int s, int addr, int len, bit gaps);
    int off = addr % W;
    int n = (len == 0) ? 0 : (off + len + W - 1) / W;
    int base = addr / W;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 2)) begin @(posedge clk); #1; end
      src_in_valid[s] = 1'b1;
      for (int j = 0; j < W; j++) src_in_data[s][j*8 +: 8] = mem_b((base + i)*W + j);
      do @(negedge clk); while (!src_in_ready[s]);
      @(posedge clk); #1;
      src_in_valid[s] = 1'b0;
    end
  endtask

  task automatic feed_res(int op, int len, bit gaps);
    int n = (len + W - 1) / W;
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 3 == 1)) begin @(posedge clk); #1; end
      res_valid = 1'b1;
      for (int j = 0; j < W; j++) res_data[j*8 +: 8] = res_b(op, i*W + j);
      do @(negedge clk); while (!res_ready);
      @(posedge clk); #1;
      res_valid = 1'b0;
    end
  endtask

  // ready patterns
  initial forever begin
    @(posedge clk); #1;
    if (stall_mode) begin
      src_out_ready[0] = (cyc % 3 != 1);
      src_out_ready[1] = (cyc % 4 != 2);
      wr_ready         = (cyc % 5 != 0);
    end else begin
      src_out_ready = 2'b11;
      wr_ready      = 1'b1;
    end
  end

  task automatic mon_src(int s);
    exp_t e;
    if (ps[s]) chk(src_out_valid[s] && src_out_data[s] == pd[s], "R9", "src held word", src_out_data[s], pd[s]);
    ps[s] = src_out_valid[s] && !src_out_ready[s];
    pd[s] = src_out_data[s];
    if (!(src_out_valid[s] && src_out_ready[s])) return;
    if ((s == 0 && qa.size() == 0) || (s == 1 && qb.size() == 0)) begin
      chk(0, "R3", "unexpected source word", src_out_data[s], '0);
      return;
    end
    e = (s == 0) ? qa.pop_front() : qb.pop_front();
    // R2 R11: aligned bytes
    chk(((src_out_data[s] ^ e.d) & bmask(e.m)) == '0, "R2", "source data",
        src_out_data[s] & bmask(e.m), e.d);
    // R6: keep and last
    chk(src_out_keep[s] == e.m && src_out_last[s] == e.last, "R6", "keep/last",
        DW'({src_out_last[s], src_out_keep[s]}), DW'({e.last, e.m}));
    if (s == 0 && fast_a) begin
      // R4: back-to-back words
      if (!first_a) chk(cyc - last_a == 1, "R4", "output gap", DW'(cyc - last_a), DW'(1));
      first_a = 0;
      last_a  = cyc;
    end
  endtask

  task automatic mon_dst();
    exp_t e;
    if (ps[2]) chk(wr_valid && wr_data == pd[2], "R9", "write held", wr_data, pd[2]);
    ps[2] = wr_valid && !wr_ready;
    pd[2] = wr_data;
    if (!(wr_valid && wr_ready)) return;
    if (qd.size() == 0) begin
      chk(0, "R8", "unexpected write", wr_data, '0);
      return;
    end
    e = qd.pop_front();
    chk(((wr_data ^ e.d) & bmask(e.m)) == '0, "R7", "write data", wr_data & bmask(e.m), e.d);
    chk(wr_be == e.m && wr_last == e.last, "R8", "byte enables/last",
        DW'({wr_last, wr_be}), DW'({e.last, e.m}));
  endtask

  always @(negedge clk) if (rst_n) begin
    mon_src(0);
    mon_src(1);
    mon_dst();
  end

  task automatic run_op(int op, int aa, int ab, int d, int len, bit stl, bit poke, string req);
    do @(negedge clk); while (!op_idle);
    stall_mode = stl;
    fast_a  = !stl;
    first_a = 1;
    expect_src(0, aa, len);
    expect_src(1, ab, len);
    expect_dst(op, d % W, len);
    @(posedge clk); #1;
    op_start = 1'b1; op_len = LW'(len);
    op_src_off[0] = OW'(aa % W); op_src_off[1] = OW'(ab % W); op_dst_off = OW'(d % W);
    @(posedge clk); #1;
    op_start = 1'b0;
    fork
      feed_src(0, aa, len, stl);
      feed_src(1, ab, len, stl);
      feed_res(op, len, stl);
      if (poke) begin
        // R10: start while busy must be ignored
        repeat (2) @(posedge clk); #1;
        op_start = 1'b1; op_len = LW'(3);
        op_src_off[0] = OW'(1); op_src_off[1] = OW'(6); op_dst_off = OW'(2);
        @(posedge clk); #1;
        op_start = 1'b0;
      end
    join
    do @(negedge clk); while (!op_idle);
    repeat (3) @(negedge clk);
    chk(qa.size() == 0 && qb.size() == 0 && qd.size() == 0 && op_idle, req, "all words seen",
        DW'(qa.size() + qb.size() + qd.size()), '0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(op_idle && src_out_valid == '0 && !wr_valid && src_in_ready == '0 && !res_ready,
        "R1", "reset outputs", DW'({op_idle, src_out_valid, wr_valid, src_in_ready, res_ready}), DW'(7'b1000000));

    run_op(1, 64, 128, 200, 16, 0, 0, "R2");        // aligned, full flow
    run_op(2, 67, 133, 206, 13, 1, 0, "R11");       // different offsets, stalls
    run_op(3, 71, 129, 207, 2, 0, 0, "R5");         // short tail, flush on B
    run_op(4, 64, 134, 203, 1, 1, 0, "R3");         // single byte
    run_op(5, 66, 141, 201, 40, 0, 0, "R4");        // long unaligned, full flow
    run_op(6, 84, 148, 212, 21, 1, 0, "R7");        // equal offsets, stalls
    run_op(7, 69, 130, 205, 30, 1, 1, "R10");       // start pulse during busy
    run_op(8, 75, 139, 219, 8, 1, 0, "R6");         // one word length, offsets

    // R3: zero-length operation
    @(posedge clk); #1;
    op_start = 1'b1; op_len = '0; op_src_off[0] = OW'(5);
    @(posedge clk); #1;
    op_start = 1'b0;
    @(negedge clk);
    chk(op_idle && src_out_valid == '0 && !wr_valid && src_in_ready == '0, "R3", "zero length",
        DW'({op_idle, src_out_valid, wr_valid, src_in_ready}), DW'(6'b100000));

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule